// File: doc/BRIEF.md
# Voltage Frequency Domain Controller

This block holds the operating point of a group of power domains. Each domain puts four tiles under one shared supply level, and each tile has its own clock speed level. A single request port carries two kinds of command. A combined step moves one domain's supply one level up or down and sets all four of its tiles to the fastest speed that the new supply permits. A speed-only command sets one tile's speed and leaves the supply alone.

Combined steps are sequenced so that no tile ever runs faster than its supply allows. On the way up, the supply moves first and the tiles are retuned only after a settling wait. On the way down, the tiles slow first and the supply drops afterwards. The supply settling wait comes from a programmable input, so a short value can stand in for the very long wait of real regulators. Speed changes use a short fixed wait. The regulator and clock circuits themselves are outside the block and appear only as the levels it drives. Software polls a per-domain busy flag, or waits for a one-cycle done pulse. Bad requests get an error pulse, and clamped speed requests get a warning pulse.

The speed limit at supply level v is fmax(v) = (v+1)*F_LEVELS/V_LEVELS - 1. With the defaults (4 supply levels, 8 speed levels) this gives 1, 3, 5 and 7.

Top module: `vfdc_top`

## Requirements
- R1: After reset, every domain is at supply level 0. Every tile is at speed fmax(0). All busy, done, error and warning outputs are 0.
- R2: A combined step (req_kind_i=0) with req_up_i=1 is accepted only from the domain's master tile, which is tile 4*d for domain d. The supply field rises by one in the cycle after the request. Tile speeds stay unchanged for settle_cycles_i+1 cycles. After that, all four tiles go to fmax of the new level.
- R3: A combined step with req_up_i=0 first sets all four tiles to fmax(v-1) in the cycle after the request. F_SETTLE+1 cycles later the supply drops by one. The sequence ends settle_cycles_i+1 cycles after that.
- R4: A speed-only command (req_kind_i=1) sets only the speed of tile req_tile_i, in the cycle after the request. The other tiles and the supply are left as they were, and the domain is busy for F_SETTLE+1 cycles.
- R5: A speed-only level above fmax of the current supply is clamped to that limit. rsp_warn_o is then 1 for one cycle.
- R6: Any request to a busy domain is rejected. rsp_err_o is 1 for one cycle, and the supply and speeds are left unchanged.
- R7: A combined step from a source tile other than the domain's master tile is rejected with rsp_err_o, and nothing changes.
- R8: A combined step up at the top supply level, or down at level 0, is rejected with rsp_err_o, and nothing changes.
- R9: A request naming a tile index at or above 24 is rejected with rsp_err_o, and no domain becomes busy.
- R10: busy_o[d] is 1 from the cycle after an accepted request until the sequence ends. done_o[d] is 1 for exactly the one cycle in which busy_o[d] first reads 0 again.
- R11: No tile's speed ever exceeds fmax of its domain's supply level. The supply changes by at most one level per cycle.
- R12: Different domains run their sequences at the same time without affecting one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| settle_cycles_i | input | 20 | Supply settling wait, latched when a combined step starts |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_kind_i | input | 1 | 0 = combined step, 1 = speed-only |
| req_up_i | input | 1 | Direction for a combined step, 1 = up |
| req_src_i | input | 5 | Tile issuing the request |
| req_tile_i | input | 5 | Target tile; for a combined step its domain is targeted |
| req_freq_i | input | 3 | Requested speed level for a speed-only command |
| rsp_err_o | output | 1 | Rejection pulse, one cycle after the request |
| rsp_warn_o | output | 1 | Clamp pulse, one cycle after the request |
| busy_o | output | 6 | Per-domain sequence in progress |
| done_o | output | 6 | Per-domain completion pulse |
| volt_lvl_o | output | 12 | Supply level of domain d at bits [2d+1:2d] |
| freq_lvl_o | output | 72 | Speed level of tile t at bits [3t+2:3t] |

## Verification
Combined steps are driven up and down on one domain with a settle value of 5. The bench samples the exact cycles around each phase edge, which shows whether supply-first and speed-first ordering are kept and whether each wait has the right length. Speed-only commands are sent once below the limit and once above it, which separates plain setting from clamping and shows that neighbouring tiles are untouched. Rejection is tried through a busy domain, a non-master source, both ends of the supply range and out-of-range tile indices. Each of these would change state differently if it slipped through. Two domains are finally started one cycle apart to expose any sharing between their sequencers.

// File: rtl/vfdc_pkg.sv
package vfdc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_VOLT = 2'd1,
    PH_FREQ = 2'd2
  } phase_e;

  localparam logic KIND_STEP = 1'b0;
  localparam logic KIND_FREQ = 1'b1;

  // highest speed level permitted at supply level v
  function automatic int unsigned fmax_of(input int unsigned v,
                                          input int unsigned nv,
                                          input int unsigned nf);
    return ((v + 1) * nf) / nv - 1;
  endfunction

endpackage

// File: rtl/vfdc_req_decode.sv
module vfdc_req_decode
  import vfdc_pkg::*;
#(
  parameter int unsigned N_DOM    = 6,
  parameter int unsigned TPD      = 4,
  parameter int unsigned V_LEVELS = 4,
  parameter int unsigned F_LEVELS = 8,
  localparam int unsigned N_TILE  = N_DOM * TPD,
  localparam int unsigned TW      = $clog2(N_TILE),
  localparam int unsigned VW      = $clog2(V_LEVELS),
  localparam int unsigned FW      = $clog2(F_LEVELS),
  localparam int unsigned SW      = (TPD > 1) ? $clog2(TPD) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_kind_i,
  input  logic                  req_up_i,
  input  logic [TW-1:0]         req_src_i,
  input  logic [TW-1:0]         req_tile_i,
  input  logic [FW-1:0]         req_freq_i,
  input  logic [N_DOM*VW-1:0]   volt_i,
  input  logic [N_DOM-1:0]      busy_i,
  output logic [N_DOM-1:0]      start_o,
  output logic [SW-1:0]         sub_o,
  output logic [FW-1:0]         flvl_o,
  output logic                  err_o,
  output logic                  warn_o
);

  logic              tile_ok, master_ok, range_ok, accept, over;
  int unsigned       dom_idx;
  logic [VW-1:0]     cur_v;
  logic [FW-1:0]     lim;

  always_comb begin
    tile_ok   = 32'(req_tile_i) < N_TILE;
    dom_idx   = tile_ok ? 32'(req_tile_i) / TPD : 0;
    sub_o     = SW'(32'(req_tile_i) % TPD);
    cur_v     = volt_i[dom_idx*VW +: VW];
    lim       = FW'(fmax_of(32'(cur_v), V_LEVELS, F_LEVELS));
    master_ok = 32'(req_src_i) == dom_idx * TPD;
    range_ok  = req_up_i ? (cur_v != VW'(V_LEVELS - 1)) : (cur_v != '0);
    accept    = req_valid_i && tile_ok && !busy_i[dom_idx] &&
                (req_kind_i == KIND_FREQ || (master_ok && range_ok));
    over      = req_freq_i > lim;
    flvl_o    = over ? lim : req_freq_i;
    err_o     = req_valid_i && !accept;
    warn_o    = accept && (req_kind_i == KIND_FREQ) && over;
    for (int d = 0; d < N_DOM; d++) start_o[d] = accept && (dom_idx == d);
  end

  // R5
  warn_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> (flvl_o < req_freq_i));

  // R12
  start_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o));

  // R6
  err_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (start_o == '0));

endmodule

// File: rtl/vfdc_domain.sv
module vfdc_domain
  import vfdc_pkg::*;
#(
  parameter int unsigned TPD      = 4,
  parameter int unsigned V_LEVELS = 4,
  parameter int unsigned F_LEVELS = 8,
  parameter int unsigned CW       = 20,
  parameter int unsigned F_SETTLE = 3,
  localparam int unsigned VW      = $clog2(V_LEVELS),
  localparam int unsigned FW      = $clog2(F_LEVELS),
  localparam int unsigned SW      = (TPD > 1) ? $clog2(TPD) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               kind_i,
  input  logic               up_i,
  input  logic [SW-1:0]      sub_i,
  input  logic [FW-1:0]      flvl_i,
  input  logic [CW-1:0]      settle_i,
  output logic [VW-1:0]      volt_o,
  output logic [TPD*FW-1:0]  freq_o,
  output logic               busy_o,
  output logic               done_o
);

  phase_e          phase_q;
  logic            up_q, kind_q, done_q;
  logic [CW-1:0]   cnt_q, settle_q;
  logic [VW-1:0]   vlvl_q;
  logic [FW-1:0]   freq_q [TPD];

  function automatic logic [FW-1:0] lim_at(input logic [VW-1:0] v);
    return FW'(fmax_of(32'(v), V_LEVELS, F_LEVELS));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      up_q     <= 1'b0;
      kind_q   <= KIND_STEP;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      settle_q <= '0;
      vlvl_q   <= '0;
      for (int t = 0; t < TPD; t++) freq_q[t] <= lim_at('0);
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          kind_q   <= kind_i;
          up_q     <= up_i;
          settle_q <= settle_i;
          if (kind_i == KIND_FREQ) begin
            freq_q[sub_i] <= flvl_i;
            cnt_q         <= CW'(F_SETTLE);
            phase_q       <= PH_FREQ;
          end else if (up_i) begin
            // supply leads on the way up
            vlvl_q  <= vlvl_q + 1'b1;
            cnt_q   <= settle_i;
            phase_q <= PH_VOLT;
          end else begin
            // speed leads on the way down
            for (int t = 0; t < TPD; t++) freq_q[t] <= lim_at(VW'(vlvl_q - 1'b1));
            cnt_q   <= CW'(F_SETTLE);
            phase_q <= PH_FREQ;
          end
        end
        PH_VOLT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (up_q) begin
            for (int t = 0; t < TPD; t++) freq_q[t] <= lim_at(vlvl_q);
            cnt_q   <= CW'(F_SETTLE);
            phase_q <= PH_FREQ;
          end else begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        PH_FREQ: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (kind_q == KIND_STEP && !up_q) begin
            vlvl_q  <= vlvl_q - 1'b1;
            cnt_q   <= settle_q;
            phase_q <= PH_VOLT;
          end else begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign volt_o = vlvl_q;
  assign busy_o = phase_q != PH_IDLE;
  assign done_o = done_q;

  for (genvar t = 0; t < TPD; t++) begin : g_tile
    assign freq_o[t*FW +: FW] = freq_q[t];

    // R11
    freq_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      freq_q[t] <= lim_at(vlvl_q));

    // R2
    up_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_VOLT && up_q && cnt_q != '0) |=> $stable(freq_q[t]));
  end

  // R11
  volt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vlvl_q != $past(vlvl_q)) |->
      ((vlvl_q == VW'($past(vlvl_q) + 1'b1)) || (VW'(vlvl_q + 1'b1) == $past(vlvl_q))));

  // R6
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (phase_q == PH_IDLE));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R4
  freq_only_volt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FREQ && kind_q == KIND_FREQ) |=> $stable(vlvl_q));

endmodule

// File: rtl/vfdc_top.sv
module vfdc_top
  import vfdc_pkg::*;
#(
  parameter int unsigned N_DOM    = 6,
  parameter int unsigned TPD      = 4,
  parameter int unsigned V_LEVELS = 4,
  parameter int unsigned F_LEVELS = 8,
  parameter int unsigned CW       = 20,
  parameter int unsigned F_SETTLE = 3,
  localparam int unsigned N_TILE  = N_DOM * TPD,
  localparam int unsigned TW      = $clog2(N_TILE),
  localparam int unsigned VW      = $clog2(V_LEVELS),
  localparam int unsigned FW      = $clog2(F_LEVELS),
  localparam int unsigned SW      = (TPD > 1) ? $clog2(TPD) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CW-1:0]        settle_cycles_i,
  input  logic                 req_valid_i,
  input  logic                 req_kind_i,
  input  logic                 req_up_i,
  input  logic [TW-1:0]        req_src_i,
  input  logic [TW-1:0]        req_tile_i,
  input  logic [FW-1:0]        req_freq_i,
  output logic                 rsp_err_o,
  output logic                 rsp_warn_o,
  output logic [N_DOM-1:0]     busy_o,
  output logic [N_DOM-1:0]     done_o,
  output logic [N_DOM*VW-1:0]  volt_lvl_o,
  output logic [N_TILE*FW-1:0] freq_lvl_o
);

  logic [N_DOM-1:0] start;
  logic [SW-1:0]    sub;
  logic [FW-1:0]    flvl;
  logic             err, warn;

  vfdc_req_decode #(
    .N_DOM(N_DOM), .TPD(TPD), .V_LEVELS(V_LEVELS), .F_LEVELS(F_LEVELS)
  ) u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .req_up_i    (req_up_i),
    .req_src_i   (req_src_i),
    .req_tile_i  (req_tile_i),
    .req_freq_i  (req_freq_i),
    .volt_i      (volt_lvl_o),
    .busy_i      (busy_o),
    .start_o     (start),
    .sub_o       (sub),
    .flvl_o      (flvl),
    .err_o       (err),
    .warn_o      (warn)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    vfdc_domain #(
      .TPD(TPD), .V_LEVELS(V_LEVELS), .F_LEVELS(F_LEVELS),
      .CW(CW), .F_SETTLE(F_SETTLE)
    ) u_dom (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start[d]),
      .kind_i   (req_kind_i),
      .up_i     (req_up_i),
      .sub_i    (sub),
      .flvl_i   (flvl),
      .settle_i (settle_cycles_i),
      .volt_o   (volt_lvl_o[d*VW +: VW]),
      .freq_o   (freq_lvl_o[d*TPD*FW +: TPD*FW]),
      .busy_o   (busy_o[d]),
      .done_o   (done_o[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_err_o  <= 1'b0;
      rsp_warn_o <= 1'b0;
    end else begin
      rsp_err_o  <= err;
      rsp_warn_o <= warn;
    end
  end

  // R9
  warn_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_err_o && rsp_warn_o));

endmodule

// File: tb/vfdc_top_tb_top.sv
module vfdc_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ND = 6;
  localparam int NT = 24;
  localparam int D  = 5;
  localparam int F  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] settle = 20'(D);
  logic        req_valid = 1'b0, req_kind = 1'b0, req_up = 1'b0;
  logic [4:0]  req_src = '0, req_tile = '0;
  logic [2:0]  req_freq = '0;
  logic        rsp_err, rsp_warn;
  logic [5:0]  busy, done;
  logic [11:0] volt;
  logic [71:0] freq;

  int  n_chk = 0, n_fail = 0;
  bit  got_err, got_warn;

  vfdc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .settle_cycles_i(settle),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_up_i(req_up),
    .req_src_i(req_src), .req_tile_i(req_tile), .req_freq_i(req_freq),
    .rsp_err_o(rsp_err), .rsp_warn_o(rsp_warn), .busy_o(busy), .done_o(done),
    .volt_lvl_o(volt), .freq_lvl_o(freq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int vget(int d); return int'(volt[d*2 +: 2]); endfunction
  function automatic int fget(int t); return int'(freq[t*3 +: 3]); endfunction
  function automatic int fm(int v);   return ((v + 1) * 8) / 4 - 1; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic send(input bit kind, input bit up, input int src, input int tile, input int fl);
    req_kind = kind; req_up = up; req_src = 5'(src); req_tile = 5'(tile);
    req_freq = 3'(fl); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got_err = rsp_err; got_warn = rsp_warn;
  endtask

  function automatic bit dom_freq_is(int d, int f);
    bit ok = 1'b1;
    for (int t = d*4; t < d*4 + 4; t++) if (fget(t) != f) ok = 1'b0;
    return ok;
  endfunction

  task automatic wait_idle(input int d);
    bit inv_ok = 1'b1;
    for (int i = 0; i < 2000 && busy[d]; i++) begin
      @(negedge clk);
      for (int t = 0; t < NT; t++) if (fget(t) > fm(vget(t/4))) inv_ok = 1'b0;
    end
    chk(inv_ok, "R11 speed above limit", 0, 1);
    chk(!busy[d], "R10 sequence never ended", int'(busy[d]), 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    bit ok = 1'b1;
    for (int d = 0; d < ND; d++) if (vget(d) != 0 || !dom_freq_is(d, fm(0))) ok = 1'b0;
    chk(ok, "R1 levels", int'(volt), 0);
    chk(busy == 0 && done == 0, "R1 busy/done", int'(busy), 0);
    chk(!rsp_err && !rsp_warn, "R1 err/warn", int'(rsp_err), 0);
  endtask

  task automatic t_step_up();
    send(1'b0, 1'b1, 4, 4, 0);
    chk(!got_err, "R2 accepted", int'(got_err), 0);
    chk(vget(1) == 1, "R2 supply first", vget(1), 1);
    chk(dom_freq_is(1, fm(0)), "R2 speed held", fget(4), fm(0));
    chk(busy[1], "R10 busy", int'(busy[1]), 1);
    repeat (D) @(negedge clk);
    chk(dom_freq_is(1, fm(0)), "R2 speed held to end of settle", fget(4), fm(0));
    @(negedge clk);
    chk(dom_freq_is(1, fm(1)), "R2 speed raised", fget(5), fm(1));
    chk(vget(0) == 0 && dom_freq_is(0, fm(0)), "R12 neighbour untouched", vget(0), 0);
    repeat (F) @(negedge clk);
    chk(busy[1] && !done[1], "R10 still busy", int'(busy[1]), 1);
    @(negedge clk);
    chk(!busy[1] && done[1], "R10 done pulse", int'(done[1]), 1);
    @(negedge clk);
    chk(!done[1], "R10 done one cycle", int'(done[1]), 0);
  endtask

  task automatic t_step_down();
    send(1'b0, 1'b0, 4, 4, 0);
    chk(!got_err, "R3 accepted", int'(got_err), 0);
    chk(dom_freq_is(1, fm(0)), "R3 speed first", fget(4), fm(0));
    chk(vget(1) == 1, "R3 supply held", vget(1), 1);
    repeat (F) @(negedge clk);
    chk(vget(1) == 1, "R3 supply held through speed wait", vget(1), 1);
    @(negedge clk);
    chk(vget(1) == 0, "R3 supply lowered", vget(1), 0);
    repeat (D) @(negedge clk);
    chk(busy[1], "R3 settle wait", int'(busy[1]), 1);
    @(negedge clk);
    chk(!busy[1] && done[1], "R3 done", int'(done[1]), 1);
    @(negedge clk);
  endtask

  task automatic t_freq_only();
    send(1'b0, 1'b1, 8, 8, 0);
    wait_idle(2);
    send(1'b1, 1'b0, 9, 9, 2);
    chk(!got_err && !got_warn, "R4 accepted no warn", int'(got_warn), 0);
    chk(fget(9) == 2, "R4 tile set", fget(9), 2);
    chk(fget(8) == 3 && fget(10) == 3 && fget(11) == 3, "R4 others kept", fget(8), 3);
    chk(vget(2) == 1, "R4 supply kept", vget(2), 1);
    repeat (F) @(negedge clk);
    chk(busy[2], "R4 busy length", int'(busy[2]), 1);
    @(negedge clk);
    chk(!busy[2] && done[2], "R4 done", int'(done[2]), 1);
    @(negedge clk);
    send(1'b1, 1'b0, 9, 10, 7);
    chk(got_warn && !got_err, "R5 warn", int'(got_warn), 1);
    chk(fget(10) == fm(1), "R5 clamped", fget(10), fm(1));
    wait_idle(2);
  endtask

  task automatic t_busy();
    send(1'b0, 1'b1, 12, 12, 0);
    send(1'b1, 1'b0, 13, 13, 0);
    chk(got_err, "R6 speed while busy", int'(got_err), 1);
    chk(fget(13) == fm(0), "R6 speed unchanged", fget(13), fm(0));
    send(1'b0, 1'b1, 12, 12, 0);
    chk(got_err, "R6 step while busy", int'(got_err), 1);
    wait_idle(3);
    chk(vget(3) == 1, "R6 supply single step", vget(3), 1);
    chk(fget(13) == fm(1), "R6 final speed", fget(13), fm(1));
  endtask

  task automatic t_master();
    send(1'b0, 1'b1, 5, 4, 0);
    chk(got_err, "R7 non-master", int'(got_err), 1);
    @(negedge clk);
    chk(vget(1) == 0 && !busy[1], "R7 nothing changed", vget(1), 0);
  endtask

  task automatic t_range();
    send(1'b0, 1'b0, 0, 0, 0);
    chk(got_err, "R8 below bottom", int'(got_err), 1);
    chk(vget(0) == 0 && !busy[0], "R8 bottom kept", vget(0), 0);
    for (int k = 0; k < 3; k++) begin
      send(1'b0, 1'b1, 20, 20, 0);
      wait_idle(5);
    end
    chk(vget(5) == 3 && dom_freq_is(5, 7), "R8 top reached", vget(5), 3);
    send(1'b0, 1'b1, 20, 20, 0);
    chk(got_err, "R8 above top", int'(got_err), 1);
    chk(vget(5) == 3 && !busy[5], "R8 top kept", vget(5), 3);
  endtask

  task automatic t_tile_range();
    send(1'b1, 1'b0, 0, 24, 0);
    chk(got_err, "R9 tile 24", int'(got_err), 1);
    send(1'b1, 1'b0, 0, 31, 7);
    chk(got_err && !got_warn, "R9 tile 31", int'(got_err), 1);
    chk(busy == 0, "R9 no domain busy", int'(busy), 0);
  endtask

  task automatic t_concurrent();
    send(1'b0, 1'b1, 0, 0, 0);
    send(1'b0, 1'b1, 16, 16, 0);
    chk(busy[0] && busy[4], "R12 both busy", int'(busy), 17);
    wait_idle(0);
    wait_idle(4);
    chk(vget(0) == 1 && vget(4) == 1, "R12 both raised", vget(4), 1);
    chk(dom_freq_is(0, fm(1)) && dom_freq_is(4, fm(1)), "R12 both speeds", fget(16), fm(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R10 watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_step_up();
    t_step_down();
    t_freq_only();
    t_busy();
    t_master();
    t_range();
    t_tile_range();
    t_concurrent();
    report();
    $finish;
  end

endmodule